// File: doc/BRIEF.md
# Falling-Edge Bus Byte Receiver

This block receives bytes from a two-wire home-automation style bus whose line is idle high and where every zero bit is sent as a low first half-bit followed by a high second half-bit. A one bit leaves the line high for the whole bit period. The receiver therefore decodes only falling edges. A falling edge places a zero in the bit slot it falls into. A slot that passes without an edge is read as a one. Each frame has one start bit, eight data bits sent least significant bit first, one parity bit and one stop bit.

Each received byte is written into a small receive FIFO with four flags: parity error, read-back mismatch, overrun and end of block. It also carries the number of whole milliseconds between its own start edge and the previous one. When the local transmitter is sending, it raises a verify flag and presents the byte it sent. A received byte that differs from that byte is flagged and produces a one-cycle flush pulse, which the transmitter uses to drop its queue. A one-cycle pulse marks every accepted start edge, so the transmitter can time its own pauses from bus activity.

Top module: `rxb_edge_receiver`

## Requirements
- R1: After the line passes through a two-flop synchronizer, a falling edge seen while idle or while waiting for the next start bit is taken as a start edge. A start edge pulses `bus_start_o` for one cycle and clears the millisecond timer. No other edge pulses it.
- R2: Bit slot k (k = 1..9) covers the interval from (k − 0.5) to (k + 0.5) bit periods after the start edge. A falling edge in slot k makes that bit 0, even when the edge is a few clocks early or late. A slot with no edge is 1. Slots 1..8 are data bits, least significant first, and slot 9 is parity.
- R3: Flag bit 0 (parity error) is set when the XOR of the eight data bits and the parity bit is 1.
- R4: The byte is decoded about 9.5 bit periods after its start edge. It is stored, without the end-of-block flag, when the next start edge arrives before 11.5 + PAUSE_BITS bit periods.
- R5: If no start edge arrives by 11.5 + PAUSE_BITS bit periods after the start edge, the pending byte is stored with flag bit 3 (end of block) set, and the receiver returns to idle.
- R6: `rd_delta_o` holds the whole milliseconds that elapsed from the previous start edge to this byte's start edge. It saturates at 65535.
- R7: `verify_i` and `tx_byte_i` are sampled when the byte is decoded. If verify was high and the byte differs from `tx_byte_i`, flag bit 1 (read-back error) is set and `flush_o` pulses for one cycle in the cycle the byte is stored.
- R8: A byte that arrives while the FIFO holds FIFO_DEPTH entries is dropped. Flag bit 2 (overrun) is then set on the newest stored entry.
- R9: With `echo_en_i` low, a byte received while verify was high is not stored. A byte received while verify was low is still stored.
- R10: The read port uses valid/ready and returns entries in arrival order. While valid is high and ready is low, the data, flags and delta stay unchanged.
- R11: After reset the FIFO is empty and neither `flush_o` nor `bus_start_o` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Raw bus line level, idle high |
| echo_en_i | input | 1 | Store bytes this node sent itself |
| verify_i | input | 1 | The byte now on the bus is this node's own transmission |
| tx_byte_i | input | 8 | Byte the local transmitter sent |
| rd_ready_i | input | 1 | Consumer accepts the head entry |
| rd_valid_o | output | 1 | FIFO holds at least one entry |
| rd_data_o | output | 8 | Received byte at the FIFO head |
| rd_flags_o | output | 4 | {end of block, overrun, read-back error, parity error} |
| rd_delta_o | output | 16 | Milliseconds between this start edge and the previous one |
| flush_o | output | 1 | One-cycle pulse asking the transmitter to drop its queue |
| bus_start_o | output | 1 | One-cycle pulse on each accepted start edge |

## Verification
A slot counter that is off by one shifts every decoded bit, so a wrong byte value appears at `rd_data_o` as soon as the first frame is popped. A slot mask that is not cleared leaves stale zeros in the next byte. A parity or read-back flag that is computed wrongly shows in `rd_flags_o` and in the number of `flush_o` pulses for that byte. Errors in the gap window or the timeout move the end-of-block bit onto the wrong entry of a block. A prescaler that does not restart at each start edge shows up as wrong millisecond deltas on bytes inside a block.

// File: rtl/rxb_pkg.sv
// Shared types for the falling-edge bus byte receiver.
package rxb_pkg;
    // Decoder phase: idle, inside a frame, or waiting for the next start edge.
    typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_GAP} dec_state_e;

    // Per-byte status bits; the bit order is visible on the read port.
    typedef struct packed {
        logic eob;
        logic ovr;
        logic rbk;
        logic perr;
    } rx_flags_t;

    // One FIFO entry: time stamp, status and the byte itself.
    typedef struct packed {
        logic [15:0] delta;
        rx_flags_t   flags;
        logic [7:0]  data;
    } rx_entry_t;
endpackage

// File: rtl/rxb_sync.sv
// Two-flop synchronizer for the bus line, followed by a falling-edge detector.
// Assumes the line idles high; the reset value matches the idle level, so
// releasing reset does not produce an edge.
module rxb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o
);
    logic s1, s2, s3;

    // Synchronizer chain plus one delayed copy for the edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= line_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall_o = s3 & ~s2;

    // R1: a falling edge is a single-cycle event.
    p_fall_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o) else $error("fall pulse longer than one cycle");
endmodule

// File: rtl/rxb_ms_timer.sv
// Millisecond counter restarted by every start edge. It saturates at 0xFFFF.
// Assumes CLKS_PER_MS >= 2.
module rxb_ms_timer #(
    parameter int CLKS_PER_MS = 10000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear_i,
    output logic [15:0] ms_o
);
    localparam int PW = $clog2(CLKS_PER_MS);

    logic [PW-1:0] pre;

    // Prescaler and saturating millisecond count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pre  <= '0;
            ms_o <= '0;
        end else if (pre == PW'(CLKS_PER_MS - 1)) begin
            pre <= '0;
            if (ms_o != 16'hFFFF) ms_o <= ms_o + 16'd1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // R6: a start edge restarts the time count.
    p_ms_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (ms_o == 16'd0)) else $error("ms count not cleared");
endmodule

// File: rtl/rxb_slot_decoder.sv
// Frame decoder driven by falling edges. From the start edge it counts bit
// slots, each centred on an expected zero-bit edge. An edge marks its slot
// as zero. At the decode point the slots that saw no edge read as ones.
// It holds the decoded byte until the next start edge or until the silence
// timeout, and then raises commit_o.
// Assumes CLKS_PER_BIT >= 4 and a fall_i that is already synchronized.
module rxb_slot_decoder import rxb_pkg::*; #(
    parameter int CLKS_PER_BIT = 1042,
    parameter int PAUSE_BITS   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fall_i,
    input  logic        verify_i,
    input  logic [7:0]  tx_byte_i,
    input  logic [15:0] ms_i,
    output logic        start_o,
    output logic        commit_o,
    output logic        own_o,
    output rx_entry_t   entry_o
);
    localparam int PHW      = $clog2(CLKS_PER_BIT);
    localparam int HALF     = CLKS_PER_BIT / 2;
    localparam int TMO_SLOT = 12 + PAUSE_BITS;
    localparam int SLW      = $clog2(TMO_SLOT + 1);

    dec_state_e     state;
    logic [PHW-1:0] phase;
    logic [SLW-1:0] slot;
    logic [9:0]     zmask, zset;
    logic           wrap, decode, tmo, in_data;
    logic [7:0]     pend_byte, dec_byte;
    logic           pend_perr, pend_rbk, pend_own;
    logic [15:0]    pend_delta;

    assign wrap     = (phase == PHW'(CLKS_PER_BIT - 1));
    assign in_data  = (slot >= SLW'(1)) && (slot <= SLW'(9));
    assign zset     = zmask | ((fall_i && state == ST_RX && in_data) ? (10'b1 << slot) : 10'b0);
    assign dec_byte = ~zset[8:1];
    assign decode   = (state == ST_RX) && wrap && (slot == SLW'(9));
    assign tmo      = (state == ST_GAP) && (slot == SLW'(TMO_SLOT));
    assign start_o  = fall_i && (state != ST_RX);
    assign commit_o = (state == ST_GAP) && (fall_i || tmo);
    assign own_o    = pend_own;

    // Assemble the entry presented at commit time.
    always_comb begin
        entry_o            = '0;
        entry_o.data       = pend_byte;
        entry_o.delta      = pend_delta;
        entry_o.flags.perr = pend_perr;
        entry_o.flags.rbk  = pend_rbk;
        entry_o.flags.eob  = !fall_i;
    end

    // Slot timing, edge capture and frame state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= '0;
            slot  <= '0;
            zmask <= '0;
        end else if (start_o) begin
            state <= ST_RX;
            phase <= PHW'(HALF);
            slot  <= '0;
            zmask <= '0;
        end else begin
            if (state != ST_IDLE) begin
                phase <= wrap ? '0 : phase + 1'b1;
                if (wrap) slot <= slot + 1'b1;
            end
            if (state == ST_RX) zmask <= zset;
            if (decode) state <= ST_GAP;
            if (tmo) state <= ST_IDLE;
        end
    end

    // Pending byte: decoded value, flags and the time stamp of its start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_byte  <= '0;
            pend_perr  <= 1'b0;
            pend_rbk   <= 1'b0;
            pend_own   <= 1'b0;
            pend_delta <= '0;
        end else begin
            if (start_o) pend_delta <= ms_i;
            if (decode) begin
                pend_byte <= dec_byte;
                pend_perr <= ^(~zset[9:1]);
                pend_own  <= verify_i;
                pend_rbk  <= verify_i && (dec_byte != tx_byte_i);
            end
        end
    end

    // R1: an accepted start edge always opens a fresh frame at slot zero.
    p_start_enters_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (state == ST_RX && slot == '0 && zmask == '0))
        else $error("start edge did not open a frame");
    // R5: silence past the window ends the block.
    p_tmo_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !fall_i) |=> (state == ST_IDLE))
        else $error("timeout did not return to idle");
    // R4: a commit always hands over the pending byte before the next frame runs.
    p_commit_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && fall_i) |=> (state == ST_RX))
        else $error("back-to-back start not accepted");
endmodule

// File: rtl/rxb_fifo.sv
// Receive FIFO with a valid/ready read port. It can also mark the overrun
// flag on its newest entry when a byte had to be dropped.
// Assumes DEPTH >= 2, so the newest entry is never the head of a full FIFO.
module rxb_fifo import rxb_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  rx_entry_t entry_i,
    input  logic      mark_ovr_i,
    input  logic      ready_i,
    output logic      valid_o,
    output logic      full_o,
    output rx_entry_t entry_o
);
    localparam int AW = $clog2(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, last_ptr;
    logic [AW:0]   count;
    logic          pop;

    assign valid_o  = (count != '0);
    assign full_o   = (count == (AW+1)'(DEPTH));
    assign pop      = valid_o && ready_i;
    assign entry_o  = mem[rd_ptr];
    assign last_ptr = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - 1'b1;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)    rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + (AW+1)'(push_i) - (AW+1)'(pop);
        end
    end

    // Entry storage and in-place overrun marking.
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= entry_i;
        if (mark_ovr_i && valid_o) mem[last_ptr].flags.ovr <= 1'b1;
    end

    // R8: the writer never pushes into a full FIFO.
    p_push_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o) else $error("push while full");
    // R10: a stalled head entry stays put.
    p_hold_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(entry_o)))
        else $error("head changed while stalled");
endmodule

// File: rtl/rxb_edge_receiver.sv
// Top level: synchronizer, millisecond timer, slot decoder and receive FIFO.
// It decides whether a committed byte is stored, dropped with an overrun
// mark, or skipped because it is an echo of this node's own transmission.
module rxb_edge_receiver import rxb_pkg::*; #(
    parameter int CLKS_PER_BIT = 1042,
    parameter int CLKS_PER_MS  = 10000,
    parameter int PAUSE_BITS   = 2,
    parameter int FIFO_DEPTH   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_i,
    input  logic        echo_en_i,
    input  logic        verify_i,
    input  logic [7:0]  tx_byte_i,
    input  logic        rd_ready_i,
    output logic        rd_valid_o,
    output logic [7:0]  rd_data_o,
    output logic [3:0]  rd_flags_o,
    output logic [15:0] rd_delta_o,
    output logic        flush_o,
    output logic        bus_start_o
);
    logic      fall, start, commit, own, full, keep, push, mark;
    logic [15:0] ms;
    rx_entry_t dec_entry, head;

    rxb_sync u_sync (.clk(clk), .rst_n(rst_n), .line_i(line_i), .fall_o(fall));

    rxb_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS)) u_ms (
        .clk(clk), .rst_n(rst_n), .clear_i(start), .ms_o(ms));

    rxb_slot_decoder #(.CLKS_PER_BIT(CLKS_PER_BIT), .PAUSE_BITS(PAUSE_BITS)) u_dec (
        .clk(clk), .rst_n(rst_n), .fall_i(fall), .verify_i(verify_i),
        .tx_byte_i(tx_byte_i), .ms_i(ms), .start_o(start), .commit_o(commit),
        .own_o(own), .entry_o(dec_entry));

    rxb_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .entry_i(dec_entry),
        .mark_ovr_i(mark), .ready_i(rd_ready_i), .valid_o(rd_valid_o),
        .full_o(full), .entry_o(head));

    assign keep        = commit && (echo_en_i || !own);
    assign push        = keep && !full;
    assign mark        = keep && full;
    assign flush_o     = push && dec_entry.flags.rbk;
    assign bus_start_o = start;
    assign rd_data_o   = head.data;
    assign rd_flags_o  = head.flags;
    assign rd_delta_o  = head.delta;

    // R7: a flush always comes with a stored byte that the reader can see.
    p_flush_stores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> rd_valid_o) else $error("flush without stored byte");
    // R11: nothing is pending in the cycle after reset.
    p_reset_empty_r11: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid_o && !flush_o)) else $error("not empty after reset");
endmodule

// File: tb/tb_rxb_edge_receiver.sv
// Bench with a behavioural reference model: a queue of expected entries that
// is updated from the frames the bench sends.
module tb_rxb_edge_receiver;
    localparam int P     = 16;
    localparam int MS    = 50;
    localparam int PAUSE = 2;
    localparam int DEPTH = 4;

    logic clk = 1'b0, rst_n = 1'b0, line = 1'b1;
    logic echo_en = 1'b1, verify = 1'b0, rd_ready = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic rd_valid, flush, bstart;
    logic [7:0] rd_data;
    logic [3:0] rd_flags;
    logic [15:0] rd_delta;

    rxb_edge_receiver #(.CLKS_PER_BIT(P), .CLKS_PER_MS(MS), .PAUSE_BITS(PAUSE),
                        .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .line_i(line), .echo_en_i(echo_en),
        .verify_i(verify), .tx_byte_i(tx_byte), .rd_ready_i(rd_ready),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_flags_o(rd_flags),
        .rd_delta_o(rd_delta), .flush_o(flush), .bus_start_o(bstart));

    always #5 clk = ~clk;

    typedef struct { logic [7:0] d; logic [3:0] f; int delta; bit dk; } exp_t;
    exp_t q[$];

    int total = 0, bad = 0, cyc = 0;
    int flush_seen = 0, flush_exp = 0, starts_seen = 0, frames = 0;
    bit done = 0;
    bit pv = 0, p_perr, p_rbk, p_own, p_dk, have_last = 0;
    logic [7:0] p_d;
    int p_delta, last_sc;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (rst_n && flush)  flush_seen++;
        if (rst_n && bstart) starts_seen++;
    end

    task automatic chk(input bit ok, input string req, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // Model: resolve the pending byte into the expected queue.
    task automatic commit(input bit eob);
        exp_t e;
        if (!pv) return;
        pv = 0;
        if (!(echo_en || !p_own)) return;          // R9
        if (q.size() < DEPTH) begin
            e.d = p_d; e.f = {eob, 1'b0, p_rbk, p_perr};
            e.delta = p_delta; e.dk = p_dk;
            q.push_back(e);
            if (p_rbk) flush_exp++;                // R7
        end else begin
            q[q.size()-1].f[2] = 1'b1;             // R8
        end
    endtask

    function automatic logic level(input int t, input logic [8:0] bits, input int skew);
        if (t < P/2) return 1'b0;
        for (int k = 1; k <= 9; k++)
            if (!bits[k-1] && t >= k*P + skew && t < k*P + skew + P/2) return 1'b0;
        return 1'b1;
    endfunction

    // Drive one frame; pbit is the parity bit sent, skew moves zero-bit edges.
    task automatic send(input logic [7:0] d, input logic pbit, input int skew,
                        input bit ver, input logic [7:0] txb);
        int diff;
        commit(1'b0);                              // R4
        diff = cyc - last_sc;
        p_dk = have_last && (diff % MS != 0);
        p_delta = (diff / MS > 65535) ? 65535 : diff / MS;   // R6
        last_sc = cyc; have_last = 1;
        verify = ver; tx_byte = txb;
        for (int t = 0; t < 11*P; t++) begin
            line = level(t, {pbit, d}, skew);
            @(negedge clk);
        end
        line = 1'b1;
        p_d = d; p_perr = ^{pbit, d}; p_own = ver; p_rbk = ver && (d != txb);
        pv = 1; frames++;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle(input int n);
        gap(n);
        commit(1'b1);                              // R5
        verify = 1'b0;
    endtask

    // Pop everything and compare with the model (R10 order).
    task automatic drain(input string req);
        exp_t e;
        while (rd_valid) begin
            if (q.size() == 0) begin
                chk(0, req, $sformatf("unexpected entry data=%h", rd_data));
            end else begin
                e = q.pop_front();
                chk(rd_data == e.d && rd_flags == e.f, req,
                    $sformatf("data/flags actual=%h/%b expected=%h/%b", rd_data, rd_flags, e.d, e.f));
                if (e.dk)
                    chk(rd_delta == 16'(e.delta), "R6",
                        $sformatf("delta actual=%0d expected=%0d", rd_delta, e.delta));
            end
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
        end
        chk(q.size() == 0, req, $sformatf("missing entries actual=0 expected=%0d", q.size()));
        q.delete();
        chk(flush_seen == flush_exp, "R7",
            $sformatf("flush count actual=%0d expected=%0d", flush_seen, flush_exp));
    endtask

    initial begin
        logic [7:0] h_d; logic [3:0] h_f; logic [15:0] h_t; bit same;
        gap(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!rd_valid, "R11", $sformatf("valid actual=%b expected=0", rd_valid));
        chk(!flush, "R11", $sformatf("flush actual=%b expected=0", flush));
        chk(!bstart, "R11", $sformatf("start actual=%b expected=0", bstart));
        gap(30);

        // R2 R4 R5: a block of back-to-back bytes, last one ends the block
        send(8'hA5, ^8'hA5, 0, 0, 0);
        send(8'h00, 1'b0, 0, 0, 0);
        send(8'hFF, 1'b0, 0, 0, 0);
        gap(20);
        send(8'h3C, ^8'h3C, 0, 0, 0);
        idle(100);
        drain("R2");

        // R3: parity error versus good parity
        send(8'h81, ~(^8'h81), 0, 0, 0);
        send(8'h81, ^8'h81, 0, 0, 0);
        idle(100);
        drain("R3");

        // R2: edges a few clocks late or early still land in their slot
        send(8'h5A, ^8'h5A, 5, 0, 0);
        send(8'h12, ^8'h12, -5, 0, 0);
        idle(100);
        drain("R2");

        // R6: exact spacing between two blocks
        send(8'h01, 1'b1, 0, 0, 0);
        idle(300);
        send(8'h02, 1'b1, 0, 0, 0);
        idle(100);
        drain("R6");

        // R7: read-back match and mismatch
        send(8'h66, ^8'h66, 0, 1, 8'h66);
        send(8'h66, ^8'h66, 0, 1, 8'h67);
        idle(100);
        drain("R7");

        // R9: echo off drops own bytes, keeps foreign ones
        echo_en = 1'b0;
        send(8'h44, ^8'h44, 0, 1, 8'h00);
        send(8'h45, ^8'h45, 0, 0, 8'h00);
        idle(100);
        drain("R9");
        echo_en = 1'b1;

        // R8: overflow with DEPTH entries
        for (int i = 0; i < 6; i++) send(8'(8'h10 + i), ^(8'(8'h10 + i)), 0, 0, 0);
        idle(100);
        drain("R8");

        // R10: stalled head stays stable
        send(8'hC3, ^8'hC3, 0, 0, 0);
        idle(100);
        h_d = rd_data; h_f = rd_flags; h_t = rd_delta; same = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!rd_valid || rd_data != h_d || rd_flags != h_f || rd_delta != h_t) same = 0;
        end
        chk(same && h_d == 8'hC3, "R10", $sformatf("held data actual=%h expected=c3 stable=%b", rd_data, same));
        drain("R10");

        // R1: one start pulse per frame
        chk(starts_seen == frames, "R1",
            $sformatf("start pulses actual=%0d expected=%0d", starts_seen, frames));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule